// File: doc/BRIEF.md
# External Interrupt and Wake Event Controller

The block watches a parameterised set of asynchronous external lines, up to 32 of them. Each line first passes through a two-flop synchroniser. A registered copy of the synchronised value then drives a small edge detector. Software chooses, line by line, whether a rising edge, a falling edge or both count as a trigger.

An enabled edge latches a sticky flag in a pending register. Software clears that flag by writing a one to it. Pending flags whose line is unmasked in the interrupt mask are ORed into one level interrupt. A second, independent mask turns enabled edges into a one-cycle wake event pulse, and this path does not involve the pending register. A software trigger register lets firmware raise a line's pending flag without any activity on the pin.

Software reaches all of this through a plain 32-bit register port with address, write strobe, write data and combinational read data. Register bits above the implemented line count can never be set. Firmware can therefore find out how many lines exist by writing all ones to a trigger register and reading it back.

Top module: `xint_ctrl`

## Requirements
- R1: After synchronous active-high reset, every register reads 0, and `irq_o` and `evt_o` are low.
- R2: Byte offsets are: 0x00 interrupt mask, 0x04 event mask, 0x08 rising-edge select, 0x0C falling-edge select, 0x10 software trigger, 0x14 pending. `bus_rdata` shows the register at `bus_addr` in the same cycle. Any other offset reads 0 and ignores writes. A write lands on the clock edge where `bus_we` is high.
- R3: When a line's bit in 0x08 is set, a 0-to-1 change on that line sets its pending bit. The bit is visible after the third rising clock edge that follows the change on the pin: two edges in the synchroniser and one into the pending register.
- R4: When a line's bit in 0x0C is set, a 1-to-0 change sets its pending bit with the same latency. With both select bits set, either direction triggers.
- R5: An edge whose direction is not selected for its line leaves the pending register unchanged.
- R6: Writing 1 to a pending bit clears it, and writing 0 leaves it alone. Without a write to 0x14, no pending bit ever falls. If a set and a clear reach the same bit in the same cycle, the set wins.
- R7: `irq_o` is high exactly when some pending bit has its 0x00 mask bit at 1. Masking a line hides its pending flag from `irq_o` but does not clear the flag.
- R8: `evt_o` rises for one cycle, on the same clock edge that records the pending flag, when an enabled edge occurs on a line whose 0x04 bit is 1. It does not depend on 0x00.
- R9: Writing 1 to a software trigger bit sets that bit. If the bit was 0 and the line's interrupt mask bit is 1, the same write also sets the line's pending bit. Writing 1 to the pending bit clears the trigger bit as well. Writing 0 to 0x10 has no effect.
- R10: Bits at or above NUM_LINES are not writable and always read 0 in every register. With the default of 20 lines, writing 0xFFFFFFFF to 0x08 reads back 0x000FFFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Write strobe for the register port |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data |
| lines_in | input | NUM_LINES | Asynchronous external lines |
| irq_o | output | 1 | Combined level interrupt |
| evt_o | output | 1 | One-cycle wake event pulse |

## Verification
The assertions assume that reset is held from time zero through at least one clock edge. They also assume that `bus_addr` and `bus_we` are driven to known values throughout, and that only word offsets are used. The bench changes `lines_in` and the bus only at the falling clock edge, so each change is seen by exactly one rising edge. The random phase toggles lines often enough that edges on several lines, and edges that arrive while a pending clear is being written, do occur. Random read addresses include an unmapped offset.

// File: rtl/xint_pkg.sv
package xint_pkg;

    localparam int unsigned REG_W = 32;

    localparam logic [31:0] OFF_IMASK = 32'h00;
    localparam logic [31:0] OFF_EMASK = 32'h04;
    localparam logic [31:0] OFF_RISE  = 32'h08;
    localparam logic [31:0] OFF_FALL  = 32'h0C;
    localparam logic [31:0] OFF_SWT   = 32'h10;
    localparam logic [31:0] OFF_PEND  = 32'h14;

    typedef enum logic [2:0] {
        SEL_IMASK,
        SEL_EMASK,
        SEL_RISE,
        SEL_FALL,
        SEL_SWT,
        SEL_PEND,
        SEL_NONE
    } xint_sel_e;

    typedef struct packed {
        logic [REG_W-1:0] imask;
        logic [REG_W-1:0] emask;
        logic [REG_W-1:0] rtrig;
        logic [REG_W-1:0] ftrig;
    } xint_cfg_t;

    function automatic logic [REG_W-1:0] line_mask(input int unsigned n);
        logic [63:0] t;
        t = (64'd1 << n) - 64'd1;
        return t[REG_W-1:0];
    endfunction

    function automatic xint_sel_e decode(input logic [31:0] a);
        xint_sel_e s;
        case (a)
            OFF_IMASK: s = SEL_IMASK;
            OFF_EMASK: s = SEL_EMASK;
            OFF_RISE:  s = SEL_RISE;
            OFF_FALL:  s = SEL_FALL;
            OFF_SWT:   s = SEL_SWT;
            OFF_PEND:  s = SEL_PEND;
            default:   s = SEL_NONE;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/xint_sync_edge.sv
module xint_sync_edge #(
    parameter int unsigned NUM_LINES = 20
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NUM_LINES-1:0] lines_in,
    output logic [NUM_LINES-1:0] rise,
    output logic [NUM_LINES-1:0] fall
);
    genvar g;
    generate
        for (g = 0; g < NUM_LINES; g++) begin : g_line
            logic s1_q, s2_q, prev_q;
            always_ff @(posedge clk) begin
                if (rst) begin
                    s1_q   <= 1'b0;
                    s2_q   <= 1'b0;
                    prev_q <= 1'b0;
                end else begin
                    s1_q   <= lines_in[g];
                    s2_q   <= s1_q;
                    prev_q <= s2_q;
                end
            end
            assign rise[g] =  s2_q & ~prev_q;
            assign fall[g] = ~s2_q &  prev_q;
        end
    endgenerate
endmodule

// File: rtl/xint_outgen.sv
module xint_outgen
    import xint_pkg::*;
#(
    parameter int unsigned NUM_LINES = 20
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [REG_W-1:0] rise,
    input  logic [REG_W-1:0] fall,
    input  xint_cfg_t        cfg,
    input  logic [REG_W-1:0] pend,
    output logic [REG_W-1:0] hit,
    output logic             irq_o,
    output logic             evt_o
);
    localparam logic [REG_W-1:0] LMASK = line_mask(NUM_LINES);

    logic evt_q;

    assign hit   = ((rise & cfg.rtrig) | (fall & cfg.ftrig)) & LMASK;
    assign irq_o = |(pend & cfg.imask);

    always_ff @(posedge clk) begin
        if (rst) evt_q <= 1'b0;
        else     evt_q <= |(hit & cfg.emask);
    end
    assign evt_o = evt_q;
endmodule

// File: rtl/xint_regfile.sv
module xint_regfile
    import xint_pkg::*;
#(
    parameter int unsigned NUM_LINES = 20,
    parameter int unsigned ADDR_W    = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [REG_W-1:0]  bus_wdata,
    output logic [REG_W-1:0]  bus_rdata,
    input  logic [REG_W-1:0]  hit,
    output xint_cfg_t         cfg,
    output logic [REG_W-1:0]  pend
);
    localparam logic [REG_W-1:0] LMASK = line_mask(NUM_LINES);

    xint_cfg_t        cfg_q;
    logic [REG_W-1:0] swt_q, pend_q;
    xint_sel_e        sel;
    logic [REG_W-1:0] wd, pclr, swwr, swset;

    assign sel   = decode(32'(bus_addr));
    assign wd    = bus_wdata & LMASK;
    assign pclr  = (bus_we && sel == SEL_PEND) ? wd : '0;
    assign swwr  = (bus_we && sel == SEL_SWT)  ? wd : '0;
    assign swset = swwr & ~swt_q & cfg_q.imask;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q  <= '0;
            swt_q  <= '0;
            pend_q <= '0;
        end else begin
            if (bus_we) begin
                case (sel)
                    SEL_IMASK: cfg_q.imask <= wd;
                    SEL_EMASK: cfg_q.emask <= wd;
                    SEL_RISE:  cfg_q.rtrig <= wd;
                    SEL_FALL:  cfg_q.ftrig <= wd;
                    default: ;
                endcase
            end
            swt_q  <= (swt_q | swwr) & ~pclr;
            pend_q <= (pend_q & ~pclr) | hit | swset;
        end
    end

    always_comb begin
        case (sel)
            SEL_IMASK: bus_rdata = cfg_q.imask;
            SEL_EMASK: bus_rdata = cfg_q.emask;
            SEL_RISE:  bus_rdata = cfg_q.rtrig;
            SEL_FALL:  bus_rdata = cfg_q.ftrig;
            SEL_SWT:   bus_rdata = swt_q;
            SEL_PEND:  bus_rdata = pend_q;
            default:   bus_rdata = '0;
        endcase
    end

    assign cfg  = cfg_q;
    assign pend = pend_q;
endmodule

// File: rtl/xint_ctrl.sv
module xint_ctrl
    import xint_pkg::*;
#(
    parameter int unsigned NUM_LINES = 20,
    parameter int unsigned ADDR_W    = 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 bus_we,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic [31:0]          bus_wdata,
    output logic [31:0]          bus_rdata,
    input  logic [NUM_LINES-1:0] lines_in,
    output logic                 irq_o,
    output logic                 evt_o
);
    logic [NUM_LINES-1:0] rise_n, fall_n;
    logic [REG_W-1:0]     rise_w, fall_w, edge_hit, pend_q;
    xint_cfg_t            cfg;

    xint_sync_edge #(.NUM_LINES(NUM_LINES)) sync_i (
        .clk(clk), .rst(rst), .lines_in(lines_in),
        .rise(rise_n), .fall(fall_n)
    );

    assign rise_w = REG_W'(rise_n);
    assign fall_w = REG_W'(fall_n);

    xint_outgen #(.NUM_LINES(NUM_LINES)) out_i (
        .clk(clk), .rst(rst), .rise(rise_w), .fall(fall_w),
        .cfg(cfg), .pend(pend_q), .hit(edge_hit),
        .irq_o(irq_o), .evt_o(evt_o)
    );

    xint_regfile #(.NUM_LINES(NUM_LINES), .ADDR_W(ADDR_W)) regs_i (
        .clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .hit(edge_hit),
        .cfg(cfg), .pend(pend_q)
    );
endmodule

// File: rtl/xint_ctrl_chk.sv
module xint_ctrl_chk
    import xint_pkg::*;
#(
    parameter int unsigned NUM_LINES = 20,
    parameter int unsigned ADDR_W    = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              bus_we,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [31:0]       bus_rdata,
    input logic              irq_o,
    input logic              evt_o,
    input logic [31:0]       pend,
    input logic [31:0]       hit
);
    localparam logic [31:0] LMASK = line_mask(NUM_LINES);

    logic pend_wr;
    assign pend_wr = bus_we && (32'(bus_addr) == OFF_PEND);

    AST_RESET_QUIET: assert property (@(posedge clk)
        rst |=> (!irq_o && !evt_o && pend == '0));                         // R1
    AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
        (bus_rdata & ~LMASK) == '0);                                         // R10
    AST_HIT_SETS: assert property (@(posedge clk) disable iff (rst)
        (hit != '0) |=> ((pend & $past(hit)) == $past(hit)));                // R3
    AST_PEND_HOLD: assert property (@(posedge clk) disable iff (rst)
        !pend_wr |=> (($past(pend) & ~pend) == '0));                         // R6
    AST_IRQ_IDLE: assert property (@(posedge clk) disable iff (rst)
        (pend == '0) |-> !irq_o);                                            // R7
    AST_EVT_CAUSE: assert property (@(posedge clk) disable iff (rst)
        evt_o |-> ($past(hit) != '0));                                       // R8
endmodule

bind xint_ctrl xint_ctrl_chk #(.NUM_LINES(NUM_LINES), .ADDR_W(ADDR_W)) chk_i (
    .clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_rdata(bus_rdata), .irq_o(irq_o), .evt_o(evt_o),
    .pend(pend_q), .hit(edge_hit)
);

// File: tb/xint_ctrl_tb_top.sv
module xint_ctrl_tb_top;
    localparam int unsigned N     = 20;
    localparam int          CLK_P = 10;
    localparam logic [31:0] LM    = 32'h000F_FFFF;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_we = 1'b0;
    logic [7:0]  bus_addr = 8'h0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [N-1:0] lines_in = '0;
    logic        irq_o, evt_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    logic [31:0] m_im, m_em, m_rt, m_ft, m_sw, m_pend, m_s1, m_s2, m_pv;
    logic        m_evt;

    always #(CLK_P/2) clk = ~clk;

    xint_ctrl #(.NUM_LINES(N), .ADDR_W(8)) dut_i (
        .clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .lines_in(lines_in),
        .irq_o(irq_o), .evt_o(evt_o)
    );

    task automatic check_eq(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [31:0] model_read(input logic [7:0] a);
        case (a)
            8'h00: return m_im;
            8'h04: return m_em;
            8'h08: return m_rt;
            8'h0C: return m_ft;
            8'h10: return m_sw;
            8'h14: return m_pend;
            default: return 32'h0;
        endcase
    endfunction

    task automatic model_reset();
        m_im = '0; m_em = '0; m_rt = '0; m_ft = '0; m_sw = '0; m_pend = '0;
        m_s1 = '0; m_s2 = '0; m_pv = '0; m_evt = 1'b0;
    endtask

    task automatic model_advance(input logic we, input logic [7:0] a,
                                 input logic [31:0] d, input logic [N-1:0] ln);
        logic [31:0] rs, fl, hit, pclr, swwr, swset, wd;
        rs    = m_s2 & ~m_pv;
        fl    = ~m_s2 & m_pv;
        hit   = ((rs & m_rt) | (fl & m_ft)) & LM;
        wd    = d & LM;
        pclr  = (we && a == 8'h14) ? wd : '0;
        swwr  = (we && a == 8'h10) ? wd : '0;
        swset = swwr & ~m_sw & m_im;
        m_evt  = |(hit & m_em);
        m_pend = (m_pend & ~pclr) | hit | swset;
        m_sw   = (m_sw | swwr) & ~pclr;
        if (we) begin
            case (a)
                8'h00: m_im = wd;
                8'h04: m_em = wd;
                8'h08: m_rt = wd;
                8'h0C: m_ft = wd;
                default: ;
            endcase
        end
        m_pv = m_s2;
        m_s2 = m_s1;
        m_s1 = 32'(ln);
    endtask

    task automatic step(input logic we, input logic [7:0] a,
                        input logic [31:0] d, input logic [N-1:0] ln);
        @(negedge clk);
        bus_we = we; bus_addr = a; bus_wdata = d; lines_in = ln;
        #1;
        check_eq("R2 read", bus_rdata, model_read(a));
        check_eq("R7 irq", 32'(irq_o), 32'(|(m_pend & m_im)));
        check_eq("R8 evt", 32'(evt_o), 32'(m_evt));
        model_advance(we, a, d, ln);
    endtask

    initial begin
        #(CLK_P * 150000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual running expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [N-1:0] ln;
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1: every register zero after reset
        for (int i = 0; i < 6; i++) begin
            step(1'b0, 8'(i * 4), '0, '0);
            check_eq("R1", bus_rdata, 32'h0);
            check_eq("R1 irq", 32'(irq_o), 32'h0);
        end

        // R10: discovery of line count
        step(1'b1, 8'h08, 32'hFFFF_FFFF, '0);
        step(1'b0, 8'h08, '0, '0);
        check_eq("R10", bus_rdata, 32'h000F_FFFF);

        // R3: rising edge latency and interrupt
        step(1'b1, 8'h00, 32'h1, '0);
        step(1'b0, 8'h14, '0, 20'h1);
        step(1'b0, 8'h14, '0, 20'h1);
        step(1'b0, 8'h14, '0, 20'h1);
        check_eq("R3 not yet", bus_rdata, 32'h0);
        step(1'b0, 8'h14, '0, 20'h1);
        check_eq("R3", bus_rdata, 32'h1);
        check_eq("R7", 32'(irq_o), 32'h1);

        // R6: writing zero keeps, writing one clears
        step(1'b1, 8'h14, 32'h0, 20'h1);
        step(1'b1, 8'h14, 32'h1, 20'h1);
        check_eq("R6 zero ignored", bus_rdata, 32'h1);
        step(1'b0, 8'h14, '0, 20'h1);
        check_eq("R6 cleared", bus_rdata, 32'h0);
        check_eq("R6 irq low", 32'(irq_o), 32'h0);

        // R4: falling edge on line 0
        step(1'b1, 8'h08, 32'h0, 20'h1);
        step(1'b1, 8'h0C, 32'h1, 20'h1);
        step(1'b0, 8'h14, '0, 20'h0);
        step(1'b0, 8'h14, '0, 20'h0);
        step(1'b0, 8'h14, '0, 20'h0);
        step(1'b0, 8'h14, '0, 20'h0);
        check_eq("R4", bus_rdata, 32'h1);
        step(1'b1, 8'h14, 32'hF_FFFF, 20'h0);

        // R5: unselected edges (rise on 0 and 1, fall only selected for 0)
        step(1'b0, 8'h14, '0, 20'h3);
        for (int i = 0; i < 4; i++) step(1'b0, 8'h14, '0, 20'h3);
        check_eq("R5", bus_rdata, 32'h0);

        // R8: event on line 2 with interrupt masked
        step(1'b1, 8'h04, 32'h4, 20'h3);
        step(1'b1, 8'h08, 32'h4, 20'h3);
        step(1'b0, 8'h14, '0, 20'h7);
        step(1'b0, 8'h14, '0, 20'h7);
        step(1'b0, 8'h14, '0, 20'h7);
        step(1'b0, 8'h14, '0, 20'h7);
        check_eq("R8 pulse", 32'(evt_o), 32'h1);
        check_eq("R7 masked", 32'(irq_o), 32'h0);
        step(1'b0, 8'h14, '0, 20'h7);
        check_eq("R8 one cycle", 32'(evt_o), 32'h0);
        check_eq("R7 still pending", bus_rdata, 32'h4);
        step(1'b1, 8'h14, 32'hF_FFFF, 20'h7);

        // R9: software trigger
        step(1'b1, 8'h00, 32'h20, 20'h7);
        step(1'b1, 8'h10, 32'h60, 20'h7);
        step(1'b0, 8'h14, '0, 20'h7);
        check_eq("R9 pend", bus_rdata, 32'h20);
        check_eq("R9 irq", 32'(irq_o), 32'h1);
        step(1'b0, 8'h10, '0, 20'h7);
        check_eq("R9 swbits", bus_rdata, 32'h60);
        step(1'b1, 8'h10, 32'h0, 20'h7);
        step(1'b1, 8'h14, 32'h60, 20'h7);
        check_eq("R9 write zero", bus_rdata, 32'h20);
        step(1'b0, 8'h10, '0, 20'h7);
        check_eq("R9 auto clear", bus_rdata, 32'h0);

        // Random phase (R2..R9 via model)
        void'($urandom(32'd1234));
        ln = 20'h7;
        for (int i = 0; i < 4000; i++) begin
            logic [7:0]  a;
            logic [31:0] d;
            logic        we;
            a  = 8'(($urandom % 7) * 4);
            we = ($urandom % 3) == 0;
            d  = ($urandom % 4 == 0) ? 32'hFFFF_FFFF : $urandom;
            if ($urandom % 3 == 0) ln = ln ^ N'($urandom);
            step(we, a, d, ln);
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule